// File: doc/BRIEF.md
# Serial-Commanded Line Sensor Sequencer

This block is the digital control core of a 102-pixel linear light sensor. A host talks to it over one serial input bit that the block captures on every rising clock edge. The bits form back-to-back 8-bit command words. These words clear the pixel integrators, begin an exposure, freeze the exposure into a sample store, start or cancel a serial readout, and load per-zone gain and offset settings. The analog front end and the converter are outside the block. They are modelled by a converter port: the block presents a pixel index, and the environment returns that pixel's 8-bit digitised value in the same cycle.

A sample command is accepted only while an exposure is running. When it is accepted, the block walks the 102 pixel indices once, one per cycle, and writes each returned value into an on-chip sample store. A read command sends the stored values out on the serial output in pixel order. Each pixel goes out as a framed 10-bit character, and the output bits change on the falling clock edge. The pixel line is split into three equal zones: pixels 0-33 are left, 34-67 are centre and 68-101 are right. Each zone has a 5-bit gain setting and an 8-bit offset setting, and these are driven out to the analog side.

Top module: `linesens_seq`

## Requirements
- R1: The serial input is captured on rising edges as consecutive 8-bit words, MSB first, with the first word starting on the first rising edge after reset is released. A word that is not a known opcode has no effect; 0x00 and 0x55 are examples.
- R2: The serial output changes only on falling clock edges and rests at 1 whenever no pixel is being sent.
- R3: Opcode 0x02 sends all 102 stored pixels, index 0 first. Each pixel takes 10 clocks: a 0 start bit, then the 8 data bits MSB first, then a 1 stop bit. The start bit of pixel 0 appears on the falling edge that follows the rising edge capturing the opcode's last bit.
- R4: Opcode 0x10 is accepted only while integrating. When accepted, it stores the converter value of every pixel, as seen just after that edge, and ends integration. In any other state it changes nothing, so a later readout still shows the older values.
- R5: Opcode 0x08 sets `integrating` to 1 from any state. Opcode 0x1B clears `integrating` to 0 and stops any readout in progress.
- R6: Opcode 0x19 stops a readout in progress. The output is 1 from the next falling edge on.
- R7: Opcode 0x02 received during a readout restarts the readout from pixel 0.
- R8: Opcode 0x40|a is a register write, and the next word is its data, which is never decoded as a command. Values of a: 0 = left gain, 1 = centre gain, 2 = right gain (each takes the low 5 data bits); 3 = left offset, 4 = centre offset, 5 = right offset (8 bits each); 6 and 7 change nothing. In `zone_gain`, zone z sits in bits [5z+4:5z]. In `zone_ofs`, zone z sits in bits [8z+7:8z].
- R9: `rst` clears `integrating`, stops the readout, drives the output to 1 and restarts word alignment. It neither initialises nor alters the gain and offset registers.
- R10: A second read with no accepted sample in between sends exactly the same values again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the serial link and all logic |
| rst | input | 1 | Synchronous active-high reset |
| sdin | input | 1 | Serial command input, captured on rising edges |
| sdout | output | 1 | Serial pixel output, updated on falling edges |
| conv_idx | output | 7 | Pixel index presented to the converter during a sample walk |
| conv_val | input | 8 | Digitised value of pixel `conv_idx` |
| integrating | output | 1 | High while an exposure is running |
| zone_gain | output | 15 | Gain settings for the three zones, 5 bits each |
| zone_ofs | output | 24 | Offset settings for the three zones, 8 bits each, sign-magnitude |

## Verification
Two functions can be active in the same cycle: the sample walk filling the store and a readout draining it. A read sent right after a sample starts streaming while the walk is still writing later pixels. The bench provokes this by issuing the read only two idle words after the sample. It then judges every output bit against a snapshot of the scene taken at the sampling edge. Stop commands and restarts are also placed so that they land in the middle of a pixel frame. In those cases the bench checks that the line goes idle, or drops to a new start bit, on the very next falling edge.

// File: rtl/linesens_pkg.sv
package linesens_pkg;
  localparam int WORD_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [WORD_W-1:0] OP_CLEAR  = 8'h1B;
  localparam logic [WORD_W-1:0] OP_START  = 8'h08;
  localparam logic [WORD_W-1:0] OP_SAMPLE = 8'h10;
  localparam logic [WORD_W-1:0] OP_READ   = 8'h02;
  localparam logic [WORD_W-1:0] OP_STOP   = 8'h19;
  localparam logic [WORD_W-1:0] OP_WRITE  = 8'h40;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_CLEAR, CMD_START, CMD_SAMPLE, CMD_READ, CMD_STOP
  } cmd_e;

  typedef enum logic [1:0] {
    EXP_CLEAR, EXP_RUN, EXP_HELD
  } exp_e;
endpackage

// File: rtl/linesens_cmd.sv
module linesens_cmd
  import linesens_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sdin,
  output cmd_e          cmd,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [W-1:0]  reg_data
);
  localparam int CNT_W = $clog2(W);

  logic [W-2:0]    shreg;
  logic [CNT_W-1:0] cnt;
  logic            want_data;
  logic [AW-1:0]   addr_q;
  logic [W-1:0]    word;
  logic            last;

  assign word = {shreg, sdin};
  assign last = (cnt == CNT_W'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      cnt       <= '0;
      want_data <= 1'b0;
      addr_q    <= '0;
    end else begin
      shreg <= word[W-2:0];
      cnt   <= last ? '0 : cnt + 1'b1;
      if (last) begin
        if (want_data) begin
          want_data <= 1'b0;
        end else if (word[W-1:AW] == OP_WRITE[W-1:AW]) begin
          want_data <= 1'b1;
          addr_q    <= word[AW-1:0];
        end
      end
    end
  end

  always_comb begin
    cmd = CMD_NONE;
    if (last && !want_data) begin
      case (word)
        OP_CLEAR:  cmd = CMD_CLEAR;
        OP_START:  cmd = CMD_START;
        OP_SAMPLE: cmd = CMD_SAMPLE;
        OP_READ:   cmd = CMD_READ;
        OP_STOP:   cmd = CMD_STOP;
        default:   cmd = CMD_NONE;
      endcase
    end
  end

  assign reg_we   = last && want_data;
  assign reg_addr = addr_q;
  assign reg_data = word;

  // R1: word boundaries repeat every W clocks
  assert_word_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    last |=> (cnt == '0));
  // R8: a data word is consumed once, never followed by a second data word
  assert_data_once_R8: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !want_data);
endmodule

// File: rtl/linesens_regs.sv
module linesens_regs #(
  parameter int ZONES  = 3,
  parameter int GAIN_W = 5,
  parameter int OFS_W  = 8,
  parameter int AW     = 3,
  parameter int W      = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [AW-1:0]             addr,
  input  logic [W-1:0]              data,
  output logic [ZONES*GAIN_W-1:0]   gain_flat,
  output logic [ZONES*OFS_W-1:0]    ofs_flat
);
  for (genvar z = 0; z < ZONES; z++) begin : g_zone
    logic [GAIN_W-1:0] gain_q;
    logic [OFS_W-1:0]  ofs_q;

    // deliberately no reset: contents are undefined until written
    always_ff @(posedge clk) begin
      if (we && addr == AW'(z))         gain_q <= data[GAIN_W-1:0];
      if (we && addr == AW'(ZONES + z)) ofs_q  <= data[OFS_W-1:0];
    end

    assign gain_flat[z*GAIN_W +: GAIN_W] = gain_q;
    assign ofs_flat[z*OFS_W +: OFS_W]    = ofs_q;

    // R8: a write to this zone's gain lands on the next cycle
    assert_gain_write_R8: assert property (@(posedge clk) disable iff (rst)
      (we && addr == AW'(z)) |=> (gain_flat[z*GAIN_W +: GAIN_W] == $past(data[GAIN_W-1:0])));
  end
endmodule

// File: rtl/linesens_smem.sv
module linesens_smem #(
  parameter int NPIX  = 102,
  parameter int PIX_W = 8,
  parameter int IDX_W = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_scan,
  output logic [IDX_W-1:0] conv_idx,
  input  logic [PIX_W-1:0] conv_val,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PIX_W-1:0] rd_q
);
  logic [PIX_W-1:0] mem [NPIX];
  logic             scan_on;
  logic [IDX_W-1:0] scan_idx;

  // one write port, one registered read port
  always_ff @(posedge clk) begin
    if (scan_on) mem[scan_idx] <= conv_val;
    rd_q <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scan_on  <= 1'b0;
      scan_idx <= '0;
    end else if (start_scan) begin
      scan_on  <= 1'b1;
      scan_idx <= '0;
    end else if (scan_on) begin
      if (scan_idx == IDX_W'(NPIX - 1)) scan_on <= 1'b0;
      else scan_idx <= scan_idx + 1'b1;
    end
  end

  assign conv_idx = scan_idx;

  // R4: the sample walk never leaves the pixel range
  assert_scan_bound_R4: assert property (@(posedge clk) disable iff (rst)
    scan_on |-> (scan_idx < IDX_W'(NPIX)));
endmodule

// File: rtl/linesens_tx.sv
module linesens_tx #(
  parameter int NPIX  = 102,
  parameter int PIX_W = 8,
  parameter int IDX_W = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             halt,
  input  logic [PIX_W-1:0] rd_q,
  output logic [IDX_W-1:0] rd_idx,
  output logic             sdout
);
  localparam int FRAME = PIX_W + 2;
  localparam int POS_W = $clog2(FRAME);
  localparam int BIT_W = $clog2(PIX_W);

  logic             busy;
  logic [POS_W-1:0] pos;
  logic [IDX_W-1:0] pix;
  logic [BIT_W-1:0] bsel;
  logic             tx;

  always_ff @(posedge clk) begin
    if (rst || halt) begin
      busy <= 1'b0;
      pos  <= '0;
      pix  <= '0;
    end else if (go) begin
      busy <= 1'b1;
      pos  <= '0;
      pix  <= '0;
    end else if (busy) begin
      if (pos == POS_W'(FRAME - 1)) begin
        pos <= '0;
        if (pix == IDX_W'(NPIX - 1)) busy <= 1'b0;
        else pix <= pix + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  assign rd_idx = pix;
  assign bsel   = BIT_W'(PIX_W - int'(pos));

  always_comb begin
    if (!busy)                         tx = 1'b1;
    else if (pos == '0)                tx = 1'b0;
    else if (pos == POS_W'(FRAME - 1)) tx = 1'b1;
    else                               tx = rd_q[bsel];
  end

  always_ff @(negedge clk) begin
    if (rst) sdout <= 1'b1;
    else     sdout <= tx;
  end

  // R3: frame position and pixel index stay in range while sending
  assert_frame_bound_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (pos < POS_W'(FRAME) && pix < IDX_W'(NPIX)));
  // R6: a stop request ends the readout on the next cycle
  assert_halt_idles_R6: assert property (@(posedge clk) disable iff (rst)
    halt |=> !busy);
  // R2: line rests high when nothing is being sent
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sdout);
endmodule

// File: rtl/linesens_seq.sv
module linesens_seq
  import linesens_pkg::*;
#(
  parameter int NPIX   = 102,
  parameter int PIX_W  = 8,
  parameter int ZONES  = 3,
  parameter int GAIN_W = 5,
  parameter int OFS_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sdin,
  output logic                    sdout,
  output logic [6:0]              conv_idx,
  input  logic [PIX_W-1:0]        conv_val,
  output logic                    integrating,
  output logic [ZONES*GAIN_W-1:0] zone_gain,
  output logic [ZONES*OFS_W-1:0]  zone_ofs
);
  localparam int IDX_W = 7;

  cmd_e              cmd;
  logic              reg_we;
  logic [ADDR_W-1:0] reg_addr;
  logic [WORD_W-1:0] reg_data;
  exp_e              state;
  logic              start_scan;
  logic [IDX_W-1:0]  rd_idx;
  logic [PIX_W-1:0]  rd_q;

  linesens_cmd #(.W(WORD_W), .AW(ADDR_W)) u_cmd (
    .clk(clk), .rst(rst), .sdin(sdin), .cmd(cmd),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_data(reg_data)
  );

  linesens_regs #(.ZONES(ZONES), .GAIN_W(GAIN_W), .OFS_W(OFS_W),
                  .AW(ADDR_W), .W(WORD_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .data(reg_data),
    .gain_flat(zone_gain), .ofs_flat(zone_ofs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= EXP_CLEAR;
    end else begin
      case (cmd)
        CMD_CLEAR:  state <= EXP_CLEAR;
        CMD_START:  state <= EXP_RUN;
        CMD_SAMPLE: if (state == EXP_RUN) state <= EXP_HELD;
        default:    state <= state;
      endcase
    end
  end

  assign integrating = (state == EXP_RUN);
  assign start_scan  = (cmd == CMD_SAMPLE) && (state == EXP_RUN);

  linesens_smem #(.NPIX(NPIX), .PIX_W(PIX_W), .IDX_W(IDX_W)) u_smem (
    .clk(clk), .rst(rst), .start_scan(start_scan),
    .conv_idx(conv_idx), .conv_val(conv_val),
    .rd_idx(rd_idx), .rd_q(rd_q)
  );

  linesens_tx #(.NPIX(NPIX), .PIX_W(PIX_W), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst(rst),
    .go(cmd == CMD_READ),
    .halt(cmd == CMD_STOP || cmd == CMD_CLEAR),
    .rd_q(rd_q), .rd_idx(rd_idx), .sdout(sdout)
  );

  // R4: a sample outside integration leaves the exposure state alone
  assert_sample_gate_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_SAMPLE && state != EXP_RUN) |=> (state == $past(state)));
  // R5: start always leads to integrating, clear always ends it
  assert_start_runs_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_START) |=> integrating);
  assert_clear_stops_R5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CLEAR) |=> !integrating);
endmodule

// File: tb/linesens_seq_bench.sv
module linesens_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sdin = 1'b0;
  logic        sdout;
  logic [6:0]  conv_idx;
  logic [7:0]  conv_val;
  logic        integrating;
  logic [14:0] zone_gain;
  logic [23:0] zone_ofs;

  always #5 clk = ~clk;

  logic [7:0] scene [102];
  assign conv_val = (conv_idx < 7'd102) ? scene[conv_idx] : 8'h00;

  linesens_seq u_linesens_seq (
    .clk(clk), .rst(rst), .sdin(sdin), .sdout(sdout),
    .conv_idx(conv_idx), .conv_val(conv_val), .integrating(integrating),
    .zone_gain(zone_gain), .zone_ofs(zone_ofs)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    finished = 0;
  string cur_tag = "R9";

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int         m_cnt = 0;
  logic [7:0] m_sh = 8'h00;
  bit         m_want = 0;
  int         m_addr = 0;
  bit         m_integ = 0;
  logic [7:0] snap [102];
  bit         exp_q [$];
  logic [4:0] m_gain [3];
  logic [7:0] m_ofs [3];
  bit         g_known [3] = '{0, 0, 0};
  bit         o_known [3] = '{0, 0, 0};

  task automatic model_word(input logic [7:0] w);
    if (m_want) begin
      m_want = 0;
      if (m_addr < 3) begin m_gain[m_addr] = w[4:0]; g_known[m_addr] = 1; end
      else if (m_addr < 6) begin m_ofs[m_addr-3] = w; o_known[m_addr-3] = 1; end
    end else begin
      case (w)
        8'h1B: begin m_integ = 0; exp_q.delete(); end
        8'h08: m_integ = 1;
        8'h10: if (m_integ) begin
                 for (int i = 0; i < 102; i++) snap[i] = scene[i];
                 m_integ = 0;
               end
        8'h02: begin
                 exp_q.delete();
                 for (int p = 0; p < 102; p++) begin
                   exp_q.push_back(1'b0);
                   for (int b = 7; b >= 0; b--) exp_q.push_back(snap[p][b]);
                   exp_q.push_back(1'b1);
                 end
               end
        8'h19: exp_q.delete();
        default: if (w[7:3] == 5'b01000) begin m_want = 1; m_addr = int'(w[2:0]); end
      endcase
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      exp_q.delete();
      m_cnt = 0; m_want = 0; m_integ = 0;
    end else begin
      m_sh = {m_sh[6:0], sdin};
      if (m_cnt == 7) begin m_cnt = 0; model_word(m_sh); end
      else m_cnt++;
    end
  end

  // ---------------- per-cycle comparison ----------------
  logic last_sd = 1'b1;
  bit   seen = 0;

  always @(negedge clk) begin
    bit e;
    #1;
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 1'b1;
    chk(sdout === e, cur_tag, "sdout", int'(sdout), int'(e));
    chk(integrating === m_integ, cur_tag, "integrating", int'(integrating), int'(m_integ));
    for (int z = 0; z < 3; z++) begin
      if (g_known[z])
        chk(zone_gain[z*5 +: 5] === m_gain[z], cur_tag, "zone_gain", int'(zone_gain[z*5 +: 5]), int'(m_gain[z]));
      if (o_known[z])
        chk(zone_ofs[z*8 +: 8] === m_ofs[z], cur_tag, "zone_ofs", int'(zone_ofs[z*8 +: 8]), int'(m_ofs[z]));
    end
    last_sd = sdout;
    seen = 1;
  end

  // R2: the output must not move around the rising edge
  always @(posedge clk) begin
    #1;
    if (seen) chk(sdout === last_sd, "R2", "sdout moved on rising edge", int'(sdout), int'(last_sd));
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdin = b[i];
      @(negedge clk); #2;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(8'h00);
  endtask

  task automatic load_scene(input int seed);
    for (int i = 0; i < 102; i++) scene[i] = 8'((i * 37 + seed) % 256);
    scene[0]   = 8'hFF;
    scene[101] = 8'h00;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: actual=running expected=done");
    summary();
  end

  initial begin
    load_scene(11);
    cur_tag = "R9";
    repeat (4) @(negedge clk);
    #2 rst = 1'b0;

    cur_tag = "R8";
    send(8'h40); send(8'h11);
    send(8'h41); send(8'h07);
    send(8'h42); send(8'h1F);
    send(8'h43); send(8'h80);
    send(8'h44); send(8'h7F);
    send(8'h45); send(8'hC3);
    send(8'h46); send(8'h02);   // unused address, data equals read opcode
    send(8'h47); send(8'h1B);
    idle(2);

    cur_tag = "R1";
    send(8'h55); send(8'hFF); send(8'h00);

    cur_tag = "R4";
    send(8'h10); idle(1);        // sample while clear: ignored
    cur_tag = "R5";
    send(8'h08); idle(2); send(8'h1B); idle(1); send(8'h08); idle(1);

    cur_tag = "R4";
    send(8'h10); idle(2);
    cur_tag = "R3";
    send(8'h02); idle(130);

    cur_tag = "R10";
    send(8'h02); idle(130);

    cur_tag = "R6";
    send(8'h02); idle(20); send(8'h19); idle(4);

    cur_tag = "R4";
    load_scene(90);
    send(8'h10);                 // held state: must not resample
    send(8'h02); idle(130);

    cur_tag = "R7";
    send(8'h02); idle(30); send(8'h02); idle(130);

    cur_tag = "R5";
    send(8'h02); idle(15); send(8'h1B); idle(4);

    cur_tag = "R4";
    send(8'h08); idle(1); send(8'h10); idle(2); send(8'h02); idle(130);

    cur_tag = "R9";
    send(8'h02); idle(10);
    rst = 1'b1;
    repeat (2) begin @(negedge clk); #2; end
    rst = 1'b0;
    idle(3);
    send(8'h08); idle(2);

    summary();
  end
endmodule